// File: doc/BRIEF.md
# Programmable Watchdog Timer with Steering

This block is a watchdog counter controlled by a single 8-bit configuration byte. The byte has three fields: a 2-bit resolution code, a 5-bit multiplier and a steering bit. The resolution code sits in bits 1:0, the multiplier in bits 6:2 and the steering bit in bit 7.

Every write to the byte reloads a down-counter with `multiplier * 4^resolution`. Every read of the byte does the same, using the value already stored. The counter then decrements once per 1/16-second tick enable. When it runs out, the block sets a timeout flag. It then does one of two things:
- With steering set, it raises a one-clock reset request, clears the configuration byte and clears bit 6 of a companion control byte.
- With steering clear, it raises a one-clock interrupt instead.

The host is expected to read or rewrite the byte periodically to keep the timeout from happening. The tick source and the system reset logic live outside the block.

Top module: `wdog_steer`

## Requirements
- R1: After reset the configuration byte, control byte and flags byte read 0, and `rst_req_o` and `irq_o` are low.
- R2: The timeout happens on the N-th tick after a reload, where N = bits[6:2] * (1 << 2*bits[1:0]) of the configuration byte. The pulse is visible in the cycle after that tick.
- R3: The counter changes only in cycles with `tick_i` high. Cycles without a tick do not advance the timeout.
- R4: A write to the configuration byte stores the value (read back on `wd_rdata_o` from the next cycle), restarts the count from the new interval and clears flag bit 7.
- R5: A read strobe on the configuration byte restarts the count from the stored value and clears flag bit 7. The stored value is unchanged.
- R6: A multiplier of zero disables the watchdog, so no timeout occurs however many ticks arrive.
- R7: On timeout, bit 7 of `flags_o` becomes 1. Bits 6:0 of `flags_o` are always 0.
- R8: On timeout with bit 7 of the configuration byte set, the block does three things: `rst_req_o` is high for exactly one cycle, the configuration byte becomes 0, and bit 6 of the control byte becomes 0 with its other bits kept.
- R9: On timeout with bit 7 clear, `irq_o` is high for exactly one cycle, and the configuration byte is kept.
- R10: A timeout is one-shot: no further pulse occurs until the next reload.
- R11: A read or write strobe in the same cycle as the final tick wins: the counter reloads and no timeout occurs. A write beats a simultaneous read.
- R12: A write to the control byte stores the value, read back on `ctrl_o` from the next cycle. A reset-path timeout in the same cycle still clears bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 1/16-second tick enable, one clock wide |
| wd_wr_i | input | 1 | Write strobe for the configuration byte |
| wd_rd_i | input | 1 | Read strobe for the configuration byte (reloads the counter) |
| wd_wdata_i | input | 8 | Write data for the configuration byte |
| wd_rdata_o | output | 8 | Stored configuration byte |
| flags_o | output | 8 | Flags byte; bit 7 is the timeout flag |
| ctrl_wr_i | input | 1 | Write strobe for the control byte |
| ctrl_wdata_i | input | 8 | Write data for the control byte |
| ctrl_o | output | 8 | Stored control byte |
| rst_req_o | output | 1 | One-cycle reset request |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The hardest situation to reach from the ports is an access strobe landing in exactly the cycle of the final tick. Random strobes rarely hit that single cycle. A directed sequence therefore loads a two-tick interval, applies one tick, and then applies the second tick together with a read strobe (and, in a later run, a write strobe).

The longest interval (1984 ticks) and a long tick-free stall are also driven directly. Random traffic with short intervals covers the rest against a cycle model in the bench.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    EVT_NONE = 2'd0,
    EVT_IRQ  = 2'd1,
    EVT_RST  = 2'd2
  } wdog_evt_e;
endpackage

// File: rtl/wdog_interval.sv
module wdog_interval #(
  parameter int MULT_W = 5,
  parameter int RES_W  = 2,
  parameter int CNT_W  = MULT_W + 2 * ((1 << RES_W) - 1)
) (
  input  logic [MULT_W-1:0] mult_i,
  input  logic [RES_W-1:0]  res_i,
  output logic [CNT_W-1:0]  ticks_o
);
  localparam int NRES = 1 << RES_W;

  logic [CNT_W-1:0] scaled [NRES];

  // one shifted copy per resolution code, step of 4x
  for (genvar g = 0; g < NRES; g++) begin : g_scale
    assign scaled[g] = CNT_W'(mult_i) << (2 * g);
  end

  assign ticks_o = scaled[res_i];
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  // last tick of a running count, unless an access reloads it
  assign expire_o = tick_i && !load_i && (cnt_q == CNT_W'(1));

  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(cnt_q)); // R3
  AST_IDLE_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !load_i) |=> (cnt_q == '0)); // R10
endmodule

// File: rtl/wdog_steer.sv
module wdog_steer
  import wdog_pkg::*;
#(
  parameter int MULT_W   = 5,
  parameter int RES_W    = 2,
  parameter int CTRL_W   = 8,
  parameter int FLAG_W   = 8,
  parameter int CTRL_BIT = 6
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          tick_i,
  input  logic                          wd_wr_i,
  input  logic                          wd_rd_i,
  input  logic [MULT_W+RES_W:0]         wd_wdata_i,
  output logic [MULT_W+RES_W:0]         wd_rdata_o,
  output logic [FLAG_W-1:0]             flags_o,
  input  logic                          ctrl_wr_i,
  input  logic [CTRL_W-1:0]             ctrl_wdata_i,
  output logic [CTRL_W-1:0]             ctrl_o,
  output logic                          rst_req_o,
  output logic                          irq_o
);
  localparam int REG_W = MULT_W + RES_W + 1;
  localparam int CNT_W = MULT_W + 2 * ((1 << RES_W) - 1);

  logic [REG_W-1:0]  wd_q;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              flag_q;
  wdog_evt_e         evt_d, evt_q;

  logic              load;
  logic [REG_W-1:0]  load_cfg;
  logic [CNT_W-1:0]  load_val;
  logic              expire;
  logic              steer;

  assign load     = wd_wr_i | wd_rd_i;
  assign load_cfg = wd_wr_i ? wd_wdata_i : wd_q;
  assign steer    = wd_q[REG_W-1];

  wdog_interval #(.MULT_W(MULT_W), .RES_W(RES_W), .CNT_W(CNT_W)) u_interval (
    .mult_i (load_cfg[RES_W +: MULT_W]),
    .res_i  (load_cfg[RES_W-1:0]),
    .ticks_o(load_val)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .load_i    (load),
    .load_val_i(load_val),
    .expire_o  (expire)
  );

  always_comb begin
    evt_d = EVT_NONE;
    if (expire) evt_d = steer ? EVT_RST : EVT_IRQ;
  end

  always_comb begin
    ctrl_d = ctrl_wr_i ? ctrl_wdata_i : ctrl_q;
    if (evt_d == EVT_RST) ctrl_d[CTRL_BIT] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wd_q   <= '0;
      ctrl_q <= '0;
      flag_q <= 1'b0;
      evt_q  <= EVT_NONE;
    end else begin
      if (wd_wr_i) wd_q <= wd_wdata_i;
      else if (evt_d == EVT_RST) wd_q <= '0;
      ctrl_q <= ctrl_d;
      if (load) flag_q <= 1'b0;
      else if (expire) flag_q <= 1'b1;
      evt_q <= evt_d;
    end
  end

  assign wd_rdata_o = wd_q;
  assign ctrl_o     = ctrl_q;
  assign flags_o    = {flag_q, {(FLAG_W-1){1'b0}}};
  assign rst_req_o  = (evt_q == EVT_RST);
  assign irq_o      = (evt_q == EVT_IRQ);

  AST_ONE_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rst_req_o && irq_o)); // R8
  AST_RST_SHORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o); // R8
  AST_IRQ_SHORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o); // R9
  AST_RST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (wd_q == '0 && !ctrl_q[CTRL_BIT])); // R8
  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_req_o || irq_o) |-> flags_o[FLAG_W-1]); // R7
  AST_ACCESS_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wd_wr_i || wd_rd_i) |=> (!flags_o[FLAG_W-1] && !rst_req_o && !irq_o)); // R11
endmodule

// File: tb/wdog_steer_test.sv
module wdog_steer_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYC = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, wd_wr = 1'b0, wd_rd = 1'b0, ctrl_wr = 1'b0;
  logic [7:0] wd_wdata = '0, ctrl_wdata = '0;
  logic [7:0] wd_rdata, flags, ctrl;
  logic       rst_req, irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // model state
  logic [7:0]  m_wd = '0, m_ctrl = '0;
  logic        m_flag = 1'b0, m_rst = 1'b0, m_irq = 1'b0;
  logic [10:0] m_cnt = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_steer uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .wd_wr_i(wd_wr), .wd_rd_i(wd_rd), .wd_wdata_i(wd_wdata), .wd_rdata_o(wd_rdata),
    .flags_o(flags), .ctrl_wr_i(ctrl_wr), .ctrl_wdata_i(ctrl_wdata), .ctrl_o(ctrl),
    .rst_req_o(rst_req), .irq_o(irq)
  );

  function automatic logic [10:0] ticks_of(input logic [7:0] v);
    // R2: multiplier bits[6:2] times 4^bits[1:0]
    return 11'(int'(v[6:2]) * (1 << (2 * int'(v[1:0]))));
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R8 rst_req", rst_req, m_rst);
    chk("R9 irq", irq, m_irq);
    chk("R7 flags", flags, {m_flag, 7'b0});
    chk("R4 wd_rdata", wd_rdata, m_wd);
    chk("R12 ctrl", ctrl, m_ctrl);
  endtask

  // apply one cycle of stimulus at negedge, advance model, check at next negedge
  task automatic cyc(input logic t, input logic wr, input logic rd, input logic [7:0] wdat,
                     input logic cwr, input logic [7:0] cdat);
    logic exp_hit, st;
    logic [7:0] c;
    tick = t; wd_wr = wr; wd_rd = rd; wd_wdata = wdat; ctrl_wr = cwr; ctrl_wdata = cdat;
    exp_hit = t && !(wr || rd) && (m_cnt == 11'd1); // R11
    st = m_wd[7];
    m_rst = exp_hit && st;
    m_irq = exp_hit && !st;
    c = cwr ? cdat : m_ctrl;
    if (exp_hit && st) c[6] = 1'b0;
    m_ctrl = c;
    if (wr) m_cnt = ticks_of(wdat);
    else if (rd) m_cnt = ticks_of(m_wd);              // R5
    else if (t && m_cnt != 0) m_cnt = m_cnt - 1'b1;   // R3
    if (wr) m_wd = wdat;
    else if (exp_hit && st) m_wd = '0;
    if (wr || rd) m_flag = 1'b0;
    else if (exp_hit) m_flag = 1'b1;
    @(negedge clk);
    check_all();
  endtask

  task automatic idle(input int n, input logic t);
    for (int i = 0; i < n; i++) cyc(t, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int seen;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 wd", wd_rdata, 0);
    chk("R1 flags", flags, 0);
    chk("R1 ctrl", ctrl, 0);
    chk("R1 pulses", {rst_req, irq}, 0);

    // R12 control write, R9 interrupt path: 0x05 -> mult 1, res 1 -> 4 ticks
    cyc(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 8'hFF);
    cyc(1'b0, 1'b1, 1'b0, 8'h05, 1'b0, 8'h00);
    seen = 0;
    for (int i = 0; i < 8; i++) begin
      cyc(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00);
      if (irq) seen = i + 1;
    end
    chk("R2 irq on 4th tick", seen, 4);
    chk("R10 no repeat", {rst_req, irq}, 0);

    // R3 + R8: 0x84 -> 1 tick, steer; long stall without ticks
    cyc(1'b0, 1'b1, 1'b0, 8'h84, 1'b0, 8'h00);
    idle(40, 1'b0);
    chk("R3 no timeout w/o tick", flags, 0);
    cyc(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00);
    chk("R8 rst pulse", rst_req, 1);
    chk("R8 ctrl bit6 cleared", ctrl, 8'hBF);
    idle(3, 1'b1);

    // R6: multiplier zero
    cyc(1'b0, 1'b1, 1'b0, 8'h83, 1'b0, 8'h00);
    idle(300, 1'b1);
    chk("R6 disabled", flags, 0);

    // R11: read on final tick reloads, then write on final tick
    cyc(1'b0, 1'b1, 1'b0, 8'h08, 1'b0, 8'h00);
    cyc(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00);
    cyc(1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 8'h00);
    chk("R11 read wins", {rst_req, irq}, 0);
    cyc(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00);
    cyc(1'b1, 1'b1, 1'b1, 8'h8C, 1'b0, 8'h00); // write beats read
    idle(3, 1'b1);
    chk("R11 write value steers", rst_req, 1);

    // R5: read strobe restarts count, stored value kept
    cyc(1'b0, 1'b1, 1'b0, 8'h0D, 1'b0, 8'h00); // 12 ticks
    idle(8, 1'b1);
    cyc(1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 8'h00);
    idle(13, 1'b1);

    // R2 longest interval 1984 ticks
    cyc(1'b0, 1'b1, 1'b0, 8'h7F, 1'b0, 8'h00);
    seen = 0;
    for (int i = 0; i < 1990; i++) begin
      cyc(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00);
      if (irq) seen = i + 1;
    end
    chk("R2 max interval", seen, 1984);

    // random traffic with short intervals
    for (int i = 0; i < 20000; i++) begin
      logic t, wr, rd, cw;
      logic [7:0] d, cd;
      t  = ($urandom_range(0, 99) < 70);
      wr = ($urandom_range(0, 99) < 3);
      rd = ($urandom_range(0, 99) < 2);
      cw = ($urandom_range(0, 99) < 5);
      d  = {1'($urandom), 3'b000, 2'($urandom), 2'($urandom_range(0, 1))};
      if ($urandom_range(0, 19) == 0) d = 8'($urandom);
      cd = 8'($urandom);
      cyc(t, wr, rd, d, cw, cd);
    end
    finish_run();
  end
endmodule